// File: doc/BRIEF.md
# Multi-drop serial transceiver with address-frame wake-up

This block is an asynchronous serial transmitter and receiver that can share one bus with many other nodes. In plain mode it moves ordinary frames. In multi-drop mode every frame carries one extra bit after the data. That bit marks the frame either as an address (ID) frame or as a payload frame. A node that is not addressed can sleep through payload traffic. Its receive interrupt stays masked by a wake latch until an ID frame arrives. That ID frame re-arms the latch by itself and raises its own interrupt.

Software drives an 8-bit control register. The register holds the transfer mode, the value of the extra bit to send, the wake latch and the transmit-interrupt source. Software writes bytes into a single-entry transmit buffer and reads the last received byte together with its extra bit. Power, transmit and receive enables come in as plain inputs. Bit timing comes from a fixed clock divider that yields a 16x oversampling tick, so one bit lasts `BAUD_DIV * OVERSAMPLE` clock cycles.

Control register layout (`cfg_wdata` / `cfg_rdata`): bits [1:0] mode (01 = multi-drop, any other value = plain framing), bit 2 outgoing extra-bit value, bit 3 wake latch, bit 4 transmit-interrupt source, bits [7:5] read as 0.

Top module: `mdrop_uart`

## Requirements
- R1: While reset is low, `cfg_rdata` reads 0x08 (plain mode, wake latch set), `tx_full` is 0 and both interrupts are 0. `txd` is 1 during reset and from the cycle after `pwr_en` goes low for as long as it stays low.
- R2: In any mode other than 01, a frame is a 0 start bit, 8 data bits LSB first and a 1 stop bit, with no extra bit. Every received frame pulses `rx_irq`, whatever the wake latch holds, and presents its byte on `rx_data` with `rx_id` = 0.
- R3: In mode 01 the transmitter inserts one extra bit between the data MSB and the stop bit. Its value is control bit 2 as sampled when the byte was accepted into the transmit buffer.
- R4: In mode 01, a received frame whose extra bit is 0 while the wake latch (bit 3) is 0 raises no `rx_irq` and leaves the latch at 0.
- R5: In mode 01, a received frame whose extra bit is 1 sets the wake latch and pulses `rx_irq` with `rx_id` = 1. While the latch stays 1, later frames with extra bit 0 also pulse `rx_irq`.
- R6: The wake latch is cleared by a control write with bit 3 = 0. It is also cleared in the cycle after `pwr_en` or `tx_en` is low. That clear wins over every set.
- R7: `tx_irq` is a one-cycle pulse. With bit 4 = 1 it pulses in the cycle after the buffered byte moves into the shifter, which is when `tx_full` falls. With bit 4 = 0 it pulses after the stop bit has fully left `txd`.
- R8: A control write changes the mode field only when `tx_en` and `rx_en` are both 0. The other fields take the write in any case.
- R9: The receiver checks the start bit at its mid-point (the 8th of 16 ticks). A low pulse that has ended by then is discarded, and the next proper frame is received normally.
- R10: The transmit buffer holds one byte. `tx_wr` while `tx_full` is 1 is ignored, and `tx_full` only sets on an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_en | input | 1 | Power enable: runs the divider, clears the wake latch when low |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | DATA_W | Byte to transmit |
| tx_full | output | 1 | Transmit buffer holds a byte not yet moved to the shifter |
| rx_data | output | DATA_W | Last received byte |
| rx_id | output | 1 | Extra bit of the last received frame (0 outside mode 01) |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
On every cycle, the assertions check the following. Both interrupts are single-cycle pulses. The mode field holds while either enable is high. The wake latch falls after a power or transmit disable. A receive interrupt in mode 01 only follows a set latch or an ID frame. The buffer fills only on a write, and the load-time interrupt coincides with the buffer draining. `txd` idles high with power off. The bench scenarios are needed for the rest: exact bit order on the line, the extra bit value and its placement, the frame-end interrupt latency, rejection of a short start glitch, and the pattern of interrupts that are delivered or suppressed over a sequence of ID and payload frames.

// File: rtl/mdrop_uart_pkg.sv
`timescale 1ns/1ps
// Shared types for the multi-drop transceiver: control register layout,
// transfer mode codes and receiver states.
package mdrop_uart_pkg;

    localparam int CFG_W = 8;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_MDROP = 2'b01,
        MODE_OPT   = 2'b10,
        MODE_RSVD  = 2'b11
    } xfer_mode_e;

    // Packed MSB first: bit4 irq source, bit3 wake latch, bit2 extra bit, [1:0] mode
    typedef struct packed {
        logic       tx_irq_sel;
        logic       rx_wake;
        logic       id_bit;
        xfer_mode_e mode;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{tx_irq_sel: 1'b0, rx_wake: 1'b1,
                                   id_bit: 1'b0, mode: MODE_PLAIN};

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

endpackage

// File: rtl/mdrop_baud.sv
`timescale 1ns/1ps
// Fixed divider producing the oversampling tick.
// Assumes DIV >= 1; the counter is held at zero while disabled.
module mdrop_baud #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == CW'(DIV - 1));

    // Count clock cycles between ticks
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mdrop_tx.sv
`timescale 1ns/1ps
// Transmit shifter. It takes a byte from the buffer when idle and sends a
// start bit, the data LSB first, an optional extra bit and a stop bit.
// Assumes OVERSAMPLE is a power of two. Disable aborts the frame.
module mdrop_tx #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              buf_valid,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              buf_app,
    input  logic              buf_has_app,
    output logic              load,
    output logic              done,
    output logic              txd
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(OVERSAMPLE);
    localparam int BITS_W  = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sh_q;
    logic               busy_q;
    logic               done_q;
    logic [CNT_W-1:0]   tcnt_q;
    logic [BITS_W-1:0]  left_q;

    assign load = en && !busy_q && buf_valid;
    assign done = done_q;
    assign txd  = busy_q ? sh_q[0] : 1'b1;

    // Load a frame, then shift one bit per OVERSAMPLE ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '1;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            tcnt_q <= '0;
            left_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!en) begin
                busy_q <= 1'b0;
                tcnt_q <= '0;
            end else if (load) begin
                busy_q <= 1'b1;
                tcnt_q <= '0;
                sh_q   <= {1'b1, (buf_has_app ? buf_app : 1'b1), buf_data, 1'b0};
                left_q <= buf_has_app ? BITS_W'(FRAME_W) : BITS_W'(FRAME_W - 1);
            end else if (busy_q && tick) begin
                if (tcnt_q == CNT_W'(OVERSAMPLE - 1)) begin
                    tcnt_q <= '0;
                    if (left_q == BITS_W'(1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
                        left_q <= left_q - 1'b1;
                    end
                end else begin
                    tcnt_q <= tcnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdrop_rx.sv
`timescale 1ns/1ps
// Receiver. It synchronises rxd, confirms the start bit at mid-bit and
// samples each bit at its centre. The extra bit is only expected when the
// multi-drop mode was active at start-bit confirmation. The stop bit value
// is not checked.
module mdrop_rx #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              rxd,
    input  logic              mp,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              app
);
    import mdrop_uart_pkg::*;

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam int HALF  = OVERSAMPLE / 2;

    logic [1:0]       sync_q;
    logic             rx_s;
    rx_state_e        st_q;
    logic [CNT_W-1:0] tcnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [DATA_W:0]  sh_q;
    logic             mp_q;
    logic             done_q;
    logic [IDX_W-1:0] last_idx;

    assign rx_s     = sync_q[1];
    assign last_idx = mp_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
    assign done     = done_q;
    assign data     = sh_q[DATA_W-1:0];
    assign app      = mp_q & sh_q[DATA_W];

    // Two-stage synchroniser for the asynchronous line
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Frame state machine, advanced on oversampling ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RX_IDLE;
            tcnt_q <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            mp_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!en) begin
                st_q   <= RX_IDLE;
                tcnt_q <= '0;
            end else if (tick) begin
                case (st_q)
                    RX_IDLE: if (!rx_s) begin
                        st_q   <= RX_START;
                        tcnt_q <= '0;
                    end
                    RX_START: if (tcnt_q == CNT_W'(HALF - 1)) begin
                        tcnt_q <= '0;
                        idx_q  <= '0;
                        mp_q   <= mp;
                        st_q   <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                    RX_DATA: if (tcnt_q == CNT_W'(OVERSAMPLE - 1)) begin
                        tcnt_q      <= '0;
                        sh_q[idx_q] <= rx_s;
                        if (idx_q == last_idx) st_q <= RX_STOP;
                        else                   idx_q <= idx_q + 1'b1;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                    RX_STOP: if (tcnt_q == CNT_W'(OVERSAMPLE - 1)) begin
                        tcnt_q <= '0;
                        st_q   <= RX_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                    default: st_q <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdrop_uart.sv
`timescale 1ns/1ps
// Multi-drop serial transceiver top. It holds the control register, the
// wake latch, the single-entry transmit buffer and the interrupt
// generation. Assumes all inputs except rxd are synchronous to clk.
module mdrop_uart #(
    parameter int DATA_W     = 8,
    parameter int BAUD_DIV   = 4,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_full,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_id,
    output logic              txd,
    input  logic              rxd,
    output logic              tx_irq,
    output logic              rx_irq
);
    import mdrop_uart_pkg::*;

    localparam int CFG_USED = $bits(cfg_t);

    cfg_t              cfg_q;
    cfg_t              wr_c;
    logic              mp;
    logic              tick;
    logic              tx_load, tx_done;
    logic              rx_done, rx_app;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] buf_data_q;
    logic              buf_app_q, buf_has_app_q, buf_full_q;
    logic [DATA_W-1:0] rx_data_q;
    logic              rx_id_q, rx_irq_q, tx_irq_q;

    assign wr_c      = cfg_t'(cfg_wdata[CFG_USED-1:0]);
    assign mp        = (cfg_q.mode == MODE_MDROP);
    assign cfg_rdata = {{(CFG_W - CFG_USED){1'b0}}, cfg_q};
    assign tx_full   = buf_full_q;
    assign rx_data   = rx_data_q;
    assign rx_id     = rx_id_q;
    assign rx_irq    = rx_irq_q;
    assign tx_irq    = tx_irq_q;

    mdrop_baud #(.DIV(BAUD_DIV)) baud_i (
        .clk(clk), .rst_n(rst_n), .en(pwr_en), .tick(tick)
    );

    mdrop_tx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) tx_i (
        .clk(clk), .rst_n(rst_n), .en(pwr_en && tx_en), .tick(tick),
        .buf_valid(buf_full_q), .buf_data(buf_data_q), .buf_app(buf_app_q),
        .buf_has_app(buf_has_app_q), .load(tx_load), .done(tx_done), .txd(txd)
    );

    mdrop_rx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) rx_i (
        .clk(clk), .rst_n(rst_n), .en(pwr_en && rx_en), .tick(tick),
        .rxd(rxd), .mp(mp), .done(rx_done), .data(rx_byte), .app(rx_app)
    );

    // Control register: mode locked while enabled, wake latch with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            if (cfg_wr) begin
                cfg_q.tx_irq_sel <= wr_c.tx_irq_sel;
                cfg_q.id_bit     <= wr_c.id_bit;
                if (!tx_en && !rx_en) cfg_q.mode <= wr_c.mode;
            end
            if (!pwr_en || !tx_en)          cfg_q.rx_wake <= 1'b0;
            else if (rx_done && mp && rx_app) cfg_q.rx_wake <= 1'b1;
            else if (cfg_wr)                cfg_q.rx_wake <= wr_c.rx_wake;
        end
    end

    // Single-entry transmit buffer; the extra bit is fixed at write time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full_q    <= 1'b0;
            buf_data_q    <= '0;
            buf_app_q     <= 1'b0;
            buf_has_app_q <= 1'b0;
        end else if (tx_wr && !buf_full_q) begin
            buf_full_q    <= 1'b1;
            buf_data_q    <= tx_data;
            buf_app_q     <= cfg_q.id_bit;
            buf_has_app_q <= mp;
        end else if (tx_load) begin
            buf_full_q    <= 1'b0;
        end
    end

    // Receive result capture and interrupt gating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_q <= '0;
            rx_id_q   <= 1'b0;
            rx_irq_q  <= 1'b0;
        end else begin
            rx_irq_q <= rx_done && (!mp || rx_app || cfg_q.rx_wake);
            if (rx_done) begin
                rx_data_q <= rx_byte;
                rx_id_q   <= rx_app;
            end
        end
    end

    // Transmit interrupt source select
    always_ff @(posedge clk) begin
        if (!rst_n) tx_irq_q <= 1'b0;
        else        tx_irq_q <= cfg_q.tx_irq_sel ? tx_load : tx_done;
    end
endmodule

// File: rtl/mdrop_uart_chk.sv
`timescale 1ns/1ps
// Property checker for mdrop_uart, attached with bind. Observes ports only.
module mdrop_uart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_en,
    input logic       tx_en,
    input logic       rx_en,
    input logic       tx_wr,
    input logic       tx_full,
    input logic       txd,
    input logic       tx_irq,
    input logic       rx_irq,
    input logic       rx_id,
    input logic [7:0] cfg_rdata
);
    a_r1_txd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> txd);

    a_r2_rx_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    a_r4_wake_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && $past(cfg_rdata[1:0]) == 2'b01) |-> ($past(cfg_rdata[3]) || rx_id));

    a_r6_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en || !tx_en) |=> !cfg_rdata[3]);

    a_r7_tx_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    a_r7_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && $past(cfg_rdata[4])) |-> $fell(tx_full));

    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en || rx_en) |=> $stable(cfg_rdata[1:0]));

    a_r10_full_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_full) |-> $past(tx_wr));
endmodule

bind mdrop_uart mdrop_uart_chk chk_i (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en(tx_en), .rx_en(rx_en),
    .tx_wr(tx_wr), .tx_full(tx_full), .txd(txd), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .rx_id(rx_id), .cfg_rdata(cfg_rdata)
);

// File: tb/mdrop_uart_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench. Driver tasks queue expected frames. One monitor matches
// receive interrupts and another decodes the serial output.
module mdrop_uart_tb_top;
    localparam int DIV = 4;
    localparam int OS  = 16;
    localparam int BIT = DIV * OS;

    typedef struct {
        logic [7:0] d;
        logic       a;
        logic       h;
    } frm_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_full;
    logic [7:0] rx_data;
    logic       rx_id, txd, tx_irq, rx_irq;
    logic       rxd = 1'b1;

    int   checks = 0, errors = 0;
    int   rx_irq_cnt = 0, tx_frames = 0;
    bit   tx_mon = 1'b0;
    frm_t rx_q[$];
    frm_t tx_q[$];
    frm_t rx_f;

    always #2.5 clk = ~clk;

    mdrop_uart #(.DATA_W(8), .BAUD_DIV(DIV), .OVERSAMPLE(OS)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en(tx_en), .rx_en(rx_en),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full),
        .rx_data(rx_data), .rx_id(rx_id), .txd(txd), .rxd(rxd),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic tx_put(input logic [7:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_data = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    // Write one byte and count negedges until tx_irq is seen
    task automatic tx_write(input logic [7:0] d, output int lat);
        tx_put(d);
        lat = 1;
        while (!tx_irq && lat < 20 * BIT) begin
            @(negedge clk); lat++;
        end
    endtask

    task automatic send_rx(input logic [7:0] d, input bit h, input bit a);
        @(negedge clk); rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (h) begin
            rxd = a;
            repeat (BIT) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    // Receive monitor: each interrupt must match the oldest expected frame
    always @(negedge clk) begin
        if (rst_n && rx_irq) begin
            rx_irq_cnt++;
            if (rx_q.size() == 0) begin
                chk(1'b0, "R4 unexpected receive interrupt", {24'h0, rx_data}, 32'h0);
            end else begin
                rx_f = rx_q.pop_front();
                chk(rx_data == rx_f.d, "R2 received byte", {24'h0, rx_data}, {24'h0, rx_f.d});
                chk(rx_id == rx_f.a, "R5 received extra bit", {31'h0, rx_id}, {31'h0, rx_f.a});
            end
        end
    end

    // Transmit monitor: decode frames from txd at bit centres
    initial begin
        forever begin
            logic [7:0] d;
            logic       a, st;
            frm_t       f;
            @(negedge txd);
            if (tx_mon) begin
                repeat (BIT / 2) @(negedge clk);
                chk(txd == 1'b0, "R2 start bit low", {31'h0, txd}, 32'h0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT) @(negedge clk);
                    d[i] = txd;
                end
                if (tx_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected transmitted frame", {24'h0, d}, 32'h0);
                end else begin
                    f = tx_q.pop_front();
                    a = 1'b0;
                    if (f.h) begin
                        repeat (BIT) @(negedge clk);
                        a = txd;
                        chk(a == f.a, "R3 extra bit value", {31'h0, a}, {31'h0, f.a});
                    end
                    repeat (BIT) @(negedge clk);
                    st = txd;
                    chk(d == f.d, "R2 transmitted byte", {24'h0, d}, {24'h0, f.d});
                    chk(st == 1'b1, "R2 stop bit high", {31'h0, st}, 32'h1);
                end
                tx_frames++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat, c0;
        repeat (3) @(negedge clk);
        chk(cfg_rdata == 8'h08, "R1 control reset value", {24'h0, cfg_rdata}, 32'h08);
        chk(txd == 1'b1 && !tx_full && !tx_irq && !rx_irq, "R1 idle outputs in reset",
            {28'h0, txd, tx_full, tx_irq, rx_irq}, 32'h8);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1 txd high with power off", {31'h0, txd}, 32'h1);
        chk(cfg_rdata == 8'h00, "R6 latch cleared by power off", {24'h0, cfg_rdata}, 32'h0);

        // R8: mode write ignored while enabled, other fields accepted
        pwr_en = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
        wr_cfg(8'h19);
        chk(cfg_rdata == 8'h18, "R8 mode locked while enabled", {24'h0, cfg_rdata}, 32'h18);

        // Plain-mode transmit, load-time interrupt (R7)
        tx_mon = 1'b1;
        tx_q.push_back('{d: 8'h5A, a: 1'b0, h: 1'b0});
        tx_write(8'h5A, lat);
        chk(lat >= 1 && lat <= 3, "R7 load-time tx_irq latency", lat, 2);
        repeat (11 * BIT) @(negedge clk);
        chk(tx_q.size() == 0, "R2 plain frame sent", tx_q.size(), 0);

        // R10: third write while full is dropped
        tx_q.push_back('{d: 8'hA3, a: 1'b0, h: 1'b0});
        tx_q.push_back('{d: 8'h3C, a: 1'b0, h: 1'b0});
        tx_put(8'hA3);
        repeat (2) @(negedge clk);
        tx_put(8'h3C);
        chk(tx_full == 1'b1, "R10 buffer full while shifter busy", {31'h0, tx_full}, 32'h1);
        tx_put(8'hFF);
        repeat (25 * BIT) @(negedge clk);
        chk(tx_q.size() == 0, "R10 queued frames sent", tx_q.size(), 0);
        chk(tx_frames == 3, "R10 write while full ignored", tx_frames, 3);

        // R2: plain-mode reception
        rx_q.push_back('{d: 8'hA5, a: 1'b0, h: 1'b0});
        send_rx(8'hA5, 1'b0, 1'b0);
        chk(rx_q.size() == 0, "R2 plain frame received", rx_q.size(), 0);
        rx_q.push_back('{d: 8'h3C, a: 1'b0, h: 1'b0});
        send_rx(8'h3C, 1'b0, 1'b0);
        chk(rx_q.size() == 0, "R2 second plain frame received", rx_q.size(), 0);

        // Enter multi-drop mode with enables off
        tx_en = 1'b0; rx_en = 1'b0;
        wr_cfg(8'h01);
        tx_en = 1'b1; rx_en = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 8'h01, "R8 mode accepted when disabled", {24'h0, cfg_rdata}, 32'h01);

        // R4: payload frame with latch clear is suppressed
        c0 = rx_irq_cnt;
        send_rx(8'h66, 1'b1, 1'b0);
        chk(rx_irq_cnt == c0, "R4 payload frame suppressed", rx_irq_cnt, c0);
        chk(cfg_rdata[3] == 1'b0, "R4 latch stays clear", {31'h0, cfg_rdata[3]}, 32'h0);

        // R5: ID frame wakes the node
        rx_q.push_back('{d: 8'h42, a: 1'b1, h: 1'b1});
        send_rx(8'h42, 1'b1, 1'b1);
        chk(rx_q.size() == 0, "R5 ID frame interrupt", rx_q.size(), 0);
        chk(cfg_rdata[3] == 1'b1, "R5 latch set by ID frame", {31'h0, cfg_rdata[3]}, 32'h1);
        rx_q.push_back('{d: 8'h17, a: 1'b0, h: 1'b1});
        send_rx(8'h17, 1'b1, 1'b0);
        chk(rx_q.size() == 0, "R5 payload after wake delivered", rx_q.size(), 0);

        // R6: software clear
        wr_cfg(8'h01);
        chk(cfg_rdata == 8'h01, "R6 latch cleared by write", {24'h0, cfg_rdata}, 32'h01);
        c0 = rx_irq_cnt;
        send_rx(8'h29, 1'b1, 1'b0);
        chk(rx_irq_cnt == c0, "R6 suppressed after clear", rx_irq_cnt, c0);

        // R6: transmit-disable clear
        wr_cfg(8'h09);
        chk(cfg_rdata == 8'h09, "R6 latch set by write", {24'h0, cfg_rdata}, 32'h09);
        @(negedge clk); tx_en = 1'b0;
        @(negedge clk); tx_en = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 8'h01, "R6 latch cleared by tx disable", {24'h0, cfg_rdata}, 32'h01);

        // R3/R7: ID frame transmit with end-of-frame interrupt
        wr_cfg(8'h05);
        tx_q.push_back('{d: 8'h81, a: 1'b1, h: 1'b1});
        tx_write(8'h81, lat);
        chk(lat >= 11 * BIT - DIV && lat <= 11 * BIT + DIV + 4, "R7 frame-end tx_irq latency", lat, 11 * BIT + 2);
        repeat (2 * BIT) @(negedge clk);
        chk(tx_q.size() == 0, "R3 ID frame sent", tx_q.size(), 0);

        wr_cfg(8'h01);
        tx_q.push_back('{d: 8'h7E, a: 1'b0, h: 1'b1});
        tx_write(8'h7E, lat);
        chk(lat >= 11 * BIT - DIV && lat <= 11 * BIT + DIV + 4, "R7 frame-end latency payload", lat, 11 * BIT + 2);
        repeat (2 * BIT) @(negedge clk);
        chk(tx_q.size() == 0, "R3 payload frame sent", tx_q.size(), 0);

        // R9: short start glitch rejected, next frame received
        wr_cfg(8'h09);
        c0 = rx_irq_cnt;
        @(negedge clk); rxd = 1'b0;
        repeat (BIT / 4) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        chk(rx_irq_cnt == c0, "R9 glitch rejected", rx_irq_cnt, c0);
        rx_q.push_back('{d: 8'hC3, a: 1'b0, h: 1'b1});
        send_rx(8'hC3, 1'b1, 1'b0);
        chk(rx_q.size() == 0, "R9 frame after glitch received", rx_q.size(), 0);

        // R2: plain mode interrupts even with latch clear
        tx_en = 1'b0; rx_en = 1'b0;
        wr_cfg(8'h00);
        tx_en = 1'b1; rx_en = 1'b1;
        rx_q.push_back('{d: 8'h5C, a: 1'b0, h: 1'b0});
        send_rx(8'h5C, 1'b0, 1'b0);
        chk(rx_q.size() == 0, "R2 plain interrupt ignores latch", rx_q.size(), 0);

        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule